// File: doc/BRIEF.md
# Overclock Watchdog Frequency Fallback

This block watches over the frequency-select code of a programmable clock generator. When the host raises the operating frequency, it can arm the watchdog. From then on the host must check in, either with a kick strobe or with any register write, before a programmed timeout runs out. If the timeout expires first, the block latches an alarm. It then replaces the active frequency code with a safe code that software chose in advance. It does not pulse a reset. The clock generator keeps running at the safe setting until software clears the alarm.

Time is counted from an external slow tick, nominally one per millisecond. A prescaler groups `TICKS_PER_UNIT` ticks into one timeout unit, 290 by default. The 8-bit count register gives the timeout in such units. Its power-up value of 16 gives about 4.6 s. A one-bit register address selects either the count register or the control register. The control register holds the fields below. Their bit positions are decoded by the neighbouring register logic.

| Bit | Field |
|-----|-------|
| 7 | Frequency source: 0 = select path, 1 = explicit divider programming |
| 6 | Watchdog enable: 1 = armed |
| 5 | Alarm status: 1 = alarm |
| 4:0 | Safe frequency code |

The active code goes out on a registered output. Whenever that code changes, a one-cycle strobe tells the frequency logic to retune.

Top module: `fsel_watchdog`

## Requirements
- R1: After reset, the count register reads 16 and the control register reads 0x00, so the watchdog is disabled. The alarm output is 0, the active code is 0 and the change strobe is 0.
- R2: While enable (control bit 6) is 0, no number of ticks raises the alarm, and the active code keeps following the select input.
- R3: With enable set and count N, the alarm rises at the clock edge that samples tick number max(N,1)×TICKS_PER_UNIT after the last reload, provided no reload comes in between. A count of 0 therefore acts as one unit.
- R4: While the alarm is set, the active code equals the safe code (control bits 4:0), and control bit 5 reads back as 1.
- R5: While enabled and not in alarm, a kick or any register write reloads the full programmed count. If the write is to the count register, the value just written is used. A kick in the same cycle as a tick wins over the tick.
- R6: During an alarm, a kick has no effect. A control write with bit 5 = 1 also has no effect, so the alarm stays set.
- R7: A control write with bit 5 = 0 clears the alarm at that edge and hands the active code back to the select path. Counting then restarts from the full count.
- R8: The change strobe is high for exactly the one cycle in which the registered active code differs from its previous value. There is no strobe when the code stays the same, including when an alarm swaps in a safe code equal to the current code.
- R9: On the normal path, the active code equals the select input registered once, one clock after it is applied.
- R10: Control bit 7 drives the divider-source output and reads back as written. It does not affect the active code.
- R11: Clearing enable stops the count at once and holds it at the reload value. Enabling again starts a full timeout.
- R12: Writing control bit 5 = 1 while no alarm is pending does not set the alarm.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Time-base tick, one cycle wide |
| kick_i | input | 1 | Host check-in strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 = count register, 1 = control register |
| wr_data_i | input | 8 | Write data |
| sel_code_i | input | 5 | Frequency code from the normal select path |
| freq_code_o | output | 5 | Active frequency code |
| freq_chg_o | output | 1 | One-cycle strobe when the active code changes |
| alarm_o | output | 1 | Alarm status |
| div_src_o | output | 1 | Frequency source selection (control bit 7) |
| rd_count_o | output | 8 | Count register readback |
| rd_ctrl_o | output | 8 | Control register readback |

## Verification
The bench sweeps the count from 0 to 5 with a three-tick unit. For each count it measures the exact tick on which the alarm fires. A prescaler that is off by one, or a zero count that never expires, shows up as a wrong tick number. Reloads are tested by kicks, by count writes, by a kick that coincides with a tick, and by disabling in the middle of a count. A design that drops a reload, or resumes a partial count, raises the alarm too early. The bench also checks that kicks and writes of bit 5 = 1 leave a pending alarm alone, and that a clearing write restores the select path. A safe code equal to the current code must produce no change strobe, which catches a strobe tied to the alarm edge instead of to a real code change.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int unsigned REG_W   = 8;
    localparam int unsigned CODE_W  = 5;

    typedef enum logic {
        ADDR_COUNT = 1'b0,
        ADDR_CTRL  = 1'b1
    } wd_addr_e;

    // Field order mirrors the control register bit positions 7..0
    typedef struct packed {
        logic              src;
        logic              en;
        logic              stat;
        logic [CODE_W-1:0] safe;
    } wd_ctrl_t;

    localparam wd_ctrl_t CTRL_RESET = '{src: 1'b0, en: 1'b0, stat: 1'b0, safe: '0};

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned CNT_RESET = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic             wr_addr_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             expire_i,
    output wd_ctrl_t         ctrl_q_o,
    output wd_ctrl_t         ctrl_d_o,
    output logic [CNT_W-1:0] count_q_o,
    output logic [CNT_W-1:0] count_d_o
);

    typedef struct packed {
        wd_ctrl_t         ctrl;
        logic [CNT_W-1:0] count;
    } regs_t;

    regs_t s_d, s_q;
    wd_ctrl_t wr_ctrl;

    assign wr_ctrl = wd_ctrl_t'(wr_data_i);

    always_comb begin
        s_d = s_q;
        if (wr_en_i) begin
            if (wd_addr_e'(wr_addr_i) == ADDR_COUNT) begin
                s_d.count = CNT_W'(wr_data_i);
            end else begin
                s_d.ctrl.src  = wr_ctrl.src;
                s_d.ctrl.en   = wr_ctrl.en;
                s_d.ctrl.safe = wr_ctrl.safe;
                // status is clear-only from software
                if (!wr_ctrl.stat) begin
                    s_d.ctrl.stat = 1'b0;
                end
            end
        end
        if (expire_i) begin
            s_d.ctrl.stat = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.ctrl  <= CTRL_RESET;
            s_q.count <= CNT_W'(CNT_RESET);
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl_q_o  = s_q.ctrl;
    assign ctrl_d_o  = s_d.ctrl;
    assign count_q_o = s_q.count;
    assign count_d_o = s_d.count;

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
    parameter int unsigned CNT_W          = 8,
    parameter int unsigned TICKS_PER_UNIT = 290
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             kick_i,
    input  logic             wr_en_i,
    input  logic             en_i,
    input  logic             alarm_i,
    input  logic [CNT_W-1:0] reload_val_i,
    output logic             expire_o
);

    localparam int unsigned UNIT_W = (TICKS_PER_UNIT > 1) ? $clog2(TICKS_PER_UNIT) : 1;
    localparam logic [UNIT_W-1:0] UNIT_LAST = UNIT_W'(TICKS_PER_UNIT - 1);

    typedef struct packed {
        logic [UNIT_W-1:0] unit;
        logic [CNT_W-1:0]  remain;
    } tmr_t;

    tmr_t s_d, s_q;
    logic hold;
    logic unit_last;
    logic last_unit;

    always_comb begin
        s_d       = s_q;
        hold      = !en_i || alarm_i || wr_en_i || kick_i;
        unit_last = (s_q.unit == UNIT_LAST);
        last_unit = (s_q.remain <= CNT_W'(1));
        expire_o  = !hold && tick_i && unit_last && last_unit;
        if (hold) begin
            s_d.unit   = '0;
            s_d.remain = reload_val_i;
        end else if (tick_i) begin
            if (unit_last) begin
                s_d.unit = '0;
                if (!last_unit) begin
                    s_d.remain = s_q.remain - CNT_W'(1);
                end
            end else begin
                s_d.unit = s_q.unit + UNIT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/fsel_mux.sv
module fsel_mux #(
    parameter int unsigned CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alarm_next_i,
    input  logic [CODE_W-1:0] safe_next_i,
    input  logic [CODE_W-1:0] sel_i,
    output logic [CODE_W-1:0] code_o,
    output logic              chg_o
);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              chg;
    } mux_t;

    mux_t s_d, s_q;

    always_comb begin
        s_d.code = alarm_next_i ? safe_next_i : sel_i;
        s_d.chg  = (s_d.code != s_q.code);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign code_o = s_q.code;
    assign chg_o  = s_q.chg;

endmodule

// File: rtl/fsel_watchdog.sv
module fsel_watchdog
    import wdog_pkg::*;
#(
    parameter int unsigned TICKS_PER_UNIT = 290,
    parameter int unsigned CNT_RESET      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              kick_i,
    input  logic              wr_en_i,
    input  logic              wr_addr_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic [CODE_W-1:0] sel_code_i,
    output logic [CODE_W-1:0] freq_code_o,
    output logic              freq_chg_o,
    output logic              alarm_o,
    output logic              div_src_o,
    output logic [REG_W-1:0]  rd_count_o,
    output logic [REG_W-1:0]  rd_ctrl_o
);

    localparam int unsigned CNT_W = REG_W;

    wd_ctrl_t         ctrl_q, ctrl_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic             expire;

    wdog_regs #(
        .CNT_W     (CNT_W),
        .CNT_RESET (CNT_RESET)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .expire_i  (expire),
        .ctrl_q_o  (ctrl_q),
        .ctrl_d_o  (ctrl_d),
        .count_q_o (count_q),
        .count_d_o (count_d)
    );

    wdog_timer #(
        .CNT_W          (CNT_W),
        .TICKS_PER_UNIT (TICKS_PER_UNIT)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .kick_i       (kick_i),
        .wr_en_i      (wr_en_i),
        .en_i         (ctrl_q.en),
        .alarm_i      (ctrl_q.stat),
        .reload_val_i (count_d),
        .expire_o     (expire)
    );

    fsel_mux #(
        .CODE_W (CODE_W)
    ) u_mux (
        .clk          (clk),
        .rst_n        (rst_n),
        .alarm_next_i (ctrl_d.stat),
        .safe_next_i  (ctrl_d.safe),
        .sel_i        (sel_code_i),
        .code_o       (freq_code_o),
        .chg_o        (freq_chg_o)
    );

    assign alarm_o    = ctrl_q.stat;
    assign div_src_o  = ctrl_q.src;
    assign rd_count_o = count_q;
    assign rd_ctrl_o  = ctrl_q;

endmodule

// File: rtl/fsel_watchdog_chk.sv
module fsel_watchdog_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic       kick_i,
    input logic       wr_en_i,
    input logic       wr_addr_i,
    input logic [7:0] wr_data_i,
    input logic [4:0] sel_code_i,
    input logic [4:0] freq_code_o,
    input logic       freq_chg_o,
    input logic       alarm_o,
    input logic [7:0] rd_ctrl_o
);

    logic clr_wr;
    assign clr_wr = wr_en_i && wr_addr_i && !wr_data_i[5];

    p_alarm_safe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_o |-> (freq_code_o == rd_ctrl_o[4:0]) && rd_ctrl_o[5]);

    p_alarm_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_o) |-> $past(rd_ctrl_o[6]));

    p_alarm_needs_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_o) |-> $past(tick_i) && !$past(kick_i) && !$past(wr_en_i));

    p_alarm_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_o && !clr_wr) |=> alarm_o);

    p_clear_works_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_o && clr_wr) |=> !alarm_o);

    p_chg_exact_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (freq_chg_o == (freq_code_o != $past(freq_code_o))));

    p_normal_path_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !alarm_o) |-> (freq_code_o == $past(sel_code_i)));

endmodule

bind fsel_watchdog fsel_watchdog_chk u_chk (.*);

// File: tb/fsel_watchdog_bench.sv
module fsel_watchdog_bench;

    localparam int CLK_PERIOD = 10;
    localparam int TPU        = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       kick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic       wr_addr_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic [4:0] sel_code_i = 5'd0;
    logic [4:0] freq_code_o;
    logic       freq_chg_o;
    logic       alarm_o;
    logic       div_src_o;
    logic [7:0] rd_count_o;
    logic [7:0] rd_ctrl_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    fsel_watchdog #(.TICKS_PER_UNIT(TPU)) u_fsel_watchdog (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .kick_i(kick_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .sel_code_i(sel_code_i), .freq_code_o(freq_code_o), .freq_chg_o(freq_chg_o),
        .alarm_o(alarm_o), .div_src_o(div_src_o), .rd_count_o(rd_count_o),
        .rd_ctrl_o(rd_ctrl_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        step();
        wr_en_i = 1'b0;
    endtask

    task automatic tick();
        tick_i = 1'b1;
        step();
        tick_i = 1'b0;
    endtask

    task automatic kick();
        kick_i = 1'b1;
        step();
        kick_i = 1'b0;
    endtask

    // ticks that must not raise the alarm
    task automatic quiet_ticks(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            tick();
            check(req, alarm_o, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        check("R1 count", rd_count_o, 16);
        check("R1 ctrl", rd_ctrl_o, 0);
        check("R1 alarm", alarm_o, 0);
        check("R1 code", freq_code_o, 0);
        check("R1 chg", freq_chg_o, 0);

        // R9 / R8 sweep of every select code
        for (int v = 1; v < 32; v++) begin
            sel_code_i = 5'(v);
            step();
            check("R9 code follows", freq_code_o, v);
            check("R8 chg on change", freq_chg_o, 1);
            step();
            check("R8 chg single", freq_chg_o, 0);
        end

        // R2 disabled: no alarm
        sel_code_i = 5'd20;
        step();
        wr(1'b0, 8'd1);
        quiet_ticks("R2 disabled", 10);
        check("R2 code", freq_code_o, 20);

        // R12 software cannot set alarm
        wr(1'b1, 8'h20);
        check("R12 alarm", alarm_o, 0);
        check("R12 stat rb", rd_ctrl_o[5], 0);

        // R3 timeout sweep, R4 safe code, R6 stickiness, R7 clear
        for (int n = 0; n < 6; n++) begin
            automatic int exp_t = ((n < 1) ? 1 : n) * TPU;
            automatic int got = -1;
            automatic int safe = n + 3;
            wr(1'b0, 8'(n));
            wr(1'b1, 8'h40 | 8'(safe));
            for (int t = 1; t <= 8 * TPU; t++) begin
                tick();
                if (alarm_o && got < 0) begin
                    got = t;
                    check("R4 code safe", freq_code_o, safe);
                    check("R4 stat rb", rd_ctrl_o[5], 1);
                    check("R8 chg at alarm", freq_chg_o, 1);
                    break;
                end
            end
            check("R3 timeout ticks", got, exp_t);
            kick();
            check("R6 kick ignored", alarm_o, 1);
            wr(1'b1, 8'h60 | 8'(safe));
            check("R6 write stat1", alarm_o, 1);
            wr(1'b1, 8'h40 | 8'(safe));
            check("R7 cleared", alarm_o, 0);
            check("R7 code back", freq_code_o, 20);
            check("R7 chg", freq_chg_o, 1);
            // R7 full count after clear
            quiet_ticks("R7 restart", exp_t - 1);
            tick();
            check("R7 restart expire", alarm_o, 1);
            wr(1'b1, 8'h00);
        end

        // R5 kick reload, kick beats tick, count write reload
        wr(1'b0, 8'd2);
        wr(1'b1, 8'h41);
        quiet_ticks("R5 pre kick", 5);
        kick();
        quiet_ticks("R5 after kick", 5);
        tick_i = 1'b1; kick_i = 1'b1;
        step();
        tick_i = 1'b0; kick_i = 1'b0;
        check("R5 kick with tick", alarm_o, 0);
        quiet_ticks("R5 after kick+tick", 5);
        wr(1'b0, 8'd1);
        quiet_ticks("R5 after count wr", 2);
        tick();
        check("R5 new count expire", alarm_o, 1);
        wr(1'b1, 8'h01);

        // R11 disable holds, re-enable full count
        wr(1'b0, 8'd2);
        wr(1'b1, 8'h41);
        quiet_ticks("R11 partial", 4);
        wr(1'b1, 8'h01);
        quiet_ticks("R11 disabled", 20);
        wr(1'b1, 8'h41);
        quiet_ticks("R11 reenabled", 5);
        tick();
        check("R11 full timeout", alarm_o, 1);
        wr(1'b1, 8'h01);

        // R8 safe code equal to current code: no strobe
        sel_code_i = 5'd7;
        step(); step();
        wr(1'b0, 8'd1);
        wr(1'b1, 8'h47);
        quiet_ticks("R8 equal pre", TPU - 1);
        tick();
        check("R8 equal alarm", alarm_o, 1);
        check("R8 equal no chg", freq_chg_o, 0);
        check("R8 equal code", freq_code_o, 7);
        wr(1'b1, 8'h07);
        check("R8 equal clear no chg", freq_chg_o, 0);

        // R10 source bit
        wr(1'b1, 8'h87);
        check("R10 div src", div_src_o, 1);
        check("R10 readback", rd_ctrl_o[7], 1);
        check("R10 code kept", freq_code_o, 7);
        check("R10 no chg", freq_chg_o, 0);
        wr(1'b1, 8'h07);
        check("R10 div src off", div_src_o, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule